// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes as asynchronous serial frames. A byte written over the bus side goes into a holding register. A shift register sends the frame on a single output line. The two registers form a double buffer: while one frame is being shifted out, the next byte can already wait in the holding register. That byte moves into the shifter on the same bit-rate tick that ends the current stop bit, so consecutive frames leave with no idle time between them.

An external one-cycle `bit_tick` strobe sets the bit rate; the block does no baud division of its own. Every bit lasts exactly one tick period, because a frame only starts on a tick. Three mode inputs pick 7 or 8 data bits, parity on or off, and even or odd parity. They are sampled when a byte moves into the shifter, so a frame that is already on the line keeps its format. The holding register resets to 0xFF. The status output `hold_empty` tells software when it may write one byte, and `tx_done` shows that all data has left.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset `tx_line` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the optional parity bit, then a 1 stop bit. Each bit is held for exactly one `bit_tick` period. A waiting byte enters the shifter only on a cycle with `bit_tick` high.
- R3: With `cfg_seven`=1 only data bits 0..6 are sent; bit 7 of the written byte never appears on the line. With `cfg_seven`=0 all 8 bits are sent.
- R4: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=0 it makes the count of ones in the data bits plus the parity bit even; with `cfg_par_odd`=1 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R5: `hold_empty` is 0 in the cycle after a write (`wr_en`=1). It returns to 1 in the cycle after the byte moves into the shifter.
- R6: A byte written while a frame is on the line starts on the tick that ends that frame's stop bit, so the line does not idle between the two frames.
- R7: `tx_done` is 1 exactly when no frame is on the line and the holding register is empty.
- R8: Changes to the mode inputs take effect at the next frame start. A frame already being shifted keeps the format it started with.
- R9: With no frame on the line, `tx_line` is 1. When `bit_tick` is low, `tx_line` does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register may be written |
| tx_done | output | 1 | Shifter idle and holding register empty |

## Verification
The assertions assume that software writes only while `hold_empty` is high and writes at most once each time the flag is set. They also assume that `bit_tick` is a single-cycle strobe. The "flag returns high after a handoff" check depends on no write landing in the handoff cycle. The stimulus meets these assumptions: every write waits at a falling edge until `hold_empty` is seen high, then pulses `wr_en` for one cycle. The tick comes from a free counter that pulses once every few clocks and can be paused to test that the line holds.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;            // start + data + parity + stop
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic seven;
    logic par_en;
    logic par_odd;
  } tx_mode_t;

  function automatic int unsigned data_len(tx_mode_t m);
    return m.seven ? DATA_W - 1 : DATA_W;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(tx_mode_t m);
    return CNT_W'(2 + data_len(m) + (m.par_en ? 1 : 0));
  endfunction

  function automatic logic parity_bit(logic [DATA_W-1:0] d, tx_mode_t m);
    logic acc;
    acc = m.par_odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(data_len(m))) acc = acc ^ d[i];
    return acc;
  endfunction

  // Frame in send order: bit 0 leaves first; unused upper bits are ones.
  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, tx_mode_t m);
    logic [FRAME_W-1:0] f;
    int unsigned len;
    f    = '1;
    f[0] = 1'b0;
    len  = data_len(m);
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(len)) f[1 + i] = d[i];
    if (m.par_en) f[1 + len] = parity_bit(d, m);
    return f;
  endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '1;
      empty_q <= 1'b1;
    end else begin
      if (wr_en) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end else if (take) begin
        empty_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_frame_gen.sv
module tx_frame_gen
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  tx_mode_t           mode,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  always_comb begin
    frame = build_frame(data, mode);
    nbits = frame_len(mode);
  end
endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               line,
  output logic               busy,
  output logic               last_bit
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= frame;
      left_q <= nbits;
    end else if (tick && left_q != '0) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end

  always_comb begin
    busy     = (left_q != '0);
    last_bit = (left_q == CNT_W'(1));
    line     = busy ? sh_q[0] : 1'b1;
  end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cfg_seven,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       bit_tick,
  output logic       tx_line,
  output logic       hold_empty,
  output logic       tx_done
);
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               sh_busy;
  logic               sh_last;
  logic               handoff;
  tx_mode_t           mode;

  assign mode    = '{seven: cfg_seven, par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign handoff = bit_tick && !hold_empty && (!sh_busy || sh_last);

  tx_hold_buf u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(handoff), .hold_q(hold_q), .empty_q(hold_empty)
  );

  tx_frame_gen u_frame (
    .data(hold_q), .mode(mode), .frame(frame), .nbits(nbits)
  );

  tx_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(handoff),
    .frame(frame), .nbits(nbits), .line(tx_line),
    .busy(sh_busy), .last_bit(sh_last)
  );

  assign tx_done = !sh_busy && hold_empty;
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic bit_tick,
  input logic tx_line,
  input logic hold_empty,
  input logic tx_done,
  input logic handoff,
  input logic sh_busy
);
  AST_START_LOW:    assert property (@(posedge clk) disable iff (!rst_n) handoff |=> !tx_line);               // R2
  AST_HANDOFF_TICK: assert property (@(posedge clk) disable iff (!rst_n) handoff |-> bit_tick);               // R2
  AST_EMPTY_CLR:    assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !hold_empty);              // R5
  AST_EMPTY_SET:    assert property (@(posedge clk) disable iff (!rst_n) (handoff && !wr_en) |=> hold_empty); // R5
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> tx_line);                // R7
  AST_IDLE_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) !sh_busy |-> tx_line);               // R9
  AST_LINE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(tx_line));     // R9
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bit_tick(bit_tick),
  .tx_line(tx_line), .hold_empty(hold_empty), .tx_done(tx_done),
  .handoff(handoff), .sh_busy(sh_busy)
);

// File: tb/test_dbuf_uart_tx.sv
module test_dbuf_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, bit_tick = 0;
  logic tx_line, hold_empty, tx_done;

  int total = 0, bad = 0;
  bit tick_en = 1;
  bit finished = 0;
  int tick_cnt = 0;
  string tag = "R1";

  // reference model state
  bit m_q[$];
  bit m_full = 0;
  logic [7:0] m_hold = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_uart_tx i_dbuf_uart_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .bit_tick(bit_tick), .tx_line(tx_line), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  task automatic push_frame(logic [7:0] d);
    int n = cfg_seven ? 7 : 8;
    int ones = 0;
    m_q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      m_q.push_back(d[i]);
      ones += d[i];
    end
    if (cfg_par_en) m_q.push_back(((ones % 2) == 1) ^ cfg_par_odd);
    m_q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_full = 0; m_hold = 8'hFF;
    end else begin
      if (bit_tick) begin
        if (m_q.size() != 0) void'(m_q.pop_front());
        if (m_q.size() == 0 && m_full) begin
          push_frame(m_hold);
          m_full = 0;
        end
      end
      if (wr_en) begin
        m_hold = wr_data;
        m_full = 1;
      end
    end
  end

  task automatic check(string t, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(tag, "tx_line",    tx_line,    (m_q.size() != 0) ? m_q[0] : 1'b1);
      check(tag, "hold_empty", hold_empty, !m_full);
      check("R7", "tx_done",   tx_done,    (m_q.size() == 0) && !m_full);
    end
  end

  // tick generator
  always @(negedge clk) begin
    if (tick_en) begin
      bit_tick = (tick_cnt == 0);
      tick_cnt = (tick_cnt + 1) % TICK_DIV;
    end else begin
      bit_tick = 0;
    end
  end

  task automatic send(logic [7:0] d);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    check("R5", "hold_empty after write", hold_empty, 1'b0);
  endtask

  task automatic drain();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "line", tx_line, 1'b1);
    check("R1", "empty", hold_empty, 1'b1);
    check("R1", "done", tx_done, 1'b1);

    tag = "R2"; send(8'hA5); send(8'h3C); drain();
    tag = "R6"; send(8'h01); send(8'h80); send(8'hFE); drain();
    tag = "R3"; cfg_seven = 1; send(8'hFF); send(8'h80); drain();
    cfg_seven = 0; send(8'h80); drain();
    tag = "R4"; cfg_par_en = 1;
    for (int k = 0; k < 4; k++) begin
      cfg_par_odd = k[0];
      send(8'h5A + 8'(k * 37)); drain();
    end
    cfg_seven = 1; cfg_par_odd = 1; send(8'h81); drain();

    tag = "R8"; cfg_seven = 0; cfg_par_en = 0;
    send(8'hC3);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    cfg_seven = 1; cfg_par_en = 1; cfg_par_odd = 1;
    send(8'h7E); drain();
    cfg_seven = 0; cfg_par_en = 0; cfg_par_odd = 0;

    tag = "R9"; tick_en = 0;
    send(8'h00);
    repeat (20) @(negedge clk);
    check("R9", "line held without tick", tx_line, 1'b1);
    check("R9", "byte still waiting", hold_empty, 1'b0);
    tick_en = 1;
    drain();
    check("R7", "done at end", tx_done, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog %s act=hung exp=finished", tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule